// File: doc/BRIEF.md
# Shift-Operand Stage with Carry

This block forms the second operand of a data-processing ALU, together with the carry bit that a shift produces. In immediate mode the operand is an 8-bit constant, zero-extended. In register mode a 32-bit source value passes through a barrel shifter. The shift amount comes from a 5-bit instruction field or from the low byte of a second register. The stage supports left and right logical shifts, arithmetic right shift, rotate right, and a one-bit rotate that passes through the carry flag. Every kind of shift produces a carry-out. This makes the result usable both for flag updates and for arithmetic that consumes the carry.

The operation is carried as a stream. A request is offered with `in_valid`. It is taken on a rising clock edge when `in_ready` is high. The result appears one cycle later on `out_operand` and `out_carry`, qualified by `out_valid`. Back-pressure works as follows. `in_ready` is high whenever the output register is empty or is being drained in the same cycle (`out_ready` high). While `out_valid` is high and `out_ready` is low, the output holds its value and no new request is taken.

Top module: `shop_operand_unit`

## Requirements
- R1: With `in_use_imm`=1 the operand is `in_imm8` zero-extended (0 to 255) and the carry equals `in_carry`. The shift kind and all amount inputs have no effect.
- R2: With `in_amt_from_reg`=1 the amount is bits 7:0 of `in_amt_reg`, and bits 31:8 are ignored. Otherwise the amount is `in_amt_imm5` (0 to 31).
- R3: Kind codes are 0 left logical, 1 right logical, 2 right arithmetic, 3 rotate right. For any of these, an amount of 0 returns the source unchanged and the carry equals `in_carry`.
- R4: Left logical by 1 to 32 shifts zeros in from bit 0. The carry is the last bit shifted out: 0x80000004 shifted by 1 gives 0x00000008 with carry 1, and a shift of 32 gives 0 with carry equal to source bit 0.
- R5: Right logical by 1 to 32 shifts zeros in from bit 31. The carry is the last bit shifted out, and a shift of 32 gives 0 with carry equal to source bit 31.
- R6: Right arithmetic by 1 to 31 copies bit 31 into the vacated bits, with carry equal to the last bit shifted out. Any amount of 32 or more gives every bit equal to source bit 31, and the carry equal to bit 31.
- R7: Rotate right uses the amount modulo 32, and the carry is result bit 31. A nonzero multiple of 32 returns the source unchanged with carry equal to source bit 31.
- R8: Kind code 4 rotates right by one through the carry: `in_carry` enters bit 31, and source bit 0 becomes the carry. The amount inputs have no effect.
- R9: Left or right logical shifts by more than 32 give 0 with carry 0.
- R10: Kind codes 5, 6 and 7 return the source unchanged, with carry equal to `in_carry`.
- R11: A request taken at an edge appears on the outputs after that edge with `out_valid` high. `in_ready` equals NOT `out_valid` OR `out_ready`. A stalled output stays stable.
- R12: While `rst_n` is low, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request offered |
| in_ready | output | 1 | Request can be taken this cycle |
| in_use_imm | input | 1 | 1 selects the 8-bit constant as operand |
| in_imm8 | input | 8 | Constant operand |
| in_src | input | 32 | Source register value to shift |
| in_kind | input | 3 | Shift kind code (0 to 4 defined, 5 to 7 pass) |
| in_amt_from_reg | input | 1 | 1 takes the amount from `in_amt_reg` |
| in_amt_imm5 | input | 5 | Amount from the instruction field |
| in_amt_reg | input | 32 | Register holding the amount in bits 7:0 |
| in_carry | input | 1 | Current carry flag |
| out_valid | output | 1 | Result held on the outputs |
| out_ready | input | 1 | Consumer takes the result |
| out_operand | output | 32 | Shifted or constant operand |
| out_carry | output | 1 | Shifter carry-out |

## Verification
Each result is due exactly one rising edge after the edge that takes its request. A stalled result stays on the outputs for every further cycle in which `out_ready` is low. The bench keeps a behavioural model that advances on the same edges. It applies the rules above to the inputs present at each edge. The model's valid, ready, operand and carry are compared with the design at every falling edge, half a period away from the edge where either side changes. Stimulus is driven one nanosecond after the rising edge, and `out_ready` is toggled at random during part of the run, so that both stalls and back-to-back transfers occur.

// File: rtl/shop_pkg.sv
package shop_pkg;
  localparam int unsigned KIND_W = 3;
  typedef enum logic [KIND_W-1:0] {
    SK_SHL  = 3'd0,
    SK_SHR  = 3'd1,
    SK_SAR  = 3'd2,
    SK_ROT  = 3'd3,
    SK_RCX  = 3'd4
  } shift_kind_e;

  function automatic logic kind_uses_amount(input logic [KIND_W-1:0] k);
    return k <= SK_ROT;
  endfunction
endpackage

// File: rtl/shop_amount_sel.sv
module shop_amount_sel #(
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned FIELD_W   = 5,
  parameter int unsigned AMT_W     = 8
) (
  input  logic               from_reg,
  input  logic [FIELD_W-1:0] field_amt,
  input  logic [DATA_W-1:0]  reg_amt,
  output logic [AMT_W-1:0]   amount,
  output logic               amount_zero
);
  localparam int unsigned PAD_W = AMT_W - FIELD_W;

  always_comb begin
    if (from_reg) amount = reg_amt[AMT_W-1:0];
    else          amount = {{PAD_W{1'b0}}, field_amt};
    amount_zero = (amount == '0);
  end
endmodule

// File: rtl/shop_barrel.sv
module shop_barrel
  import shop_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned AMT_W  = 8
) (
  input  logic [DATA_W-1:0] src,
  input  logic [KIND_W-1:0] kind,
  input  logic [AMT_W-1:0]  amount,
  input  logic              amount_zero,
  input  logic              carry_in,
  output logic [DATA_W-1:0] result,
  output logic              carry_out
);
  localparam int unsigned ROT_W = $clog2(DATA_W);

  // Each path carries one extra bit that catches the last bit shifted out.
  logic [DATA_W:0]    left_ext;
  logic [DATA_W:0]    right_ext;
  logic [DATA_W:0]    arith_ext;
  logic [ROT_W-1:0]   rot_amt;
  logic [DATA_W-1:0]  rot_val;

  always_comb begin
    left_ext  = {1'b0, src} << amount;
    right_ext = {src, 1'b0} >> amount;
    arith_ext = $signed({src, 1'b0}) >>> amount;
    rot_amt   = amount[ROT_W-1:0];
    rot_val   = (src >> rot_amt) | (src << (DATA_W - int'(rot_amt)));
  end

  always_comb begin
    result    = src;
    carry_out = carry_in;
    if (kind == SK_RCX) begin
      result    = {carry_in, src[DATA_W-1:1]};
      carry_out = src[0];
    end else if (kind_uses_amount(kind) && !amount_zero) begin
      unique case (kind)
        SK_SHL: begin
          result    = left_ext[DATA_W-1:0];
          carry_out = left_ext[DATA_W];
        end
        SK_SHR: begin
          result    = right_ext[DATA_W:1];
          carry_out = right_ext[0];
        end
        SK_SAR: begin
          result    = arith_ext[DATA_W:1];
          carry_out = arith_ext[0];
        end
        default: begin
          result    = rot_val;
          carry_out = rot_val[DATA_W-1];
        end
      endcase
    end
  end
endmodule

// File: rtl/shop_out_stage.sv
module shop_out_stage #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_operand,
  input  logic              in_carry,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_operand,
  output logic              out_carry
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_operand <= '0;
      out_carry   <= 1'b0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_operand <= in_operand;
        out_carry   <= in_carry;
      end
    end
  end

  a_r11_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_operand) && $stable(out_carry)));

  a_r11_taken_shows: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  a_r11_drained_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !in_valid) |=> !out_valid);
endmodule

// File: rtl/shop_operand_unit.sv
module shop_operand_unit
  import shop_pkg::*;
#(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned IMM_W   = 8,
  parameter int unsigned FIELD_W = 5,
  parameter int unsigned AMT_W   = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic               in_use_imm,
  input  logic [IMM_W-1:0]   in_imm8,
  input  logic [DATA_W-1:0]  in_src,
  input  logic [KIND_W-1:0]  in_kind,
  input  logic               in_amt_from_reg,
  input  logic [FIELD_W-1:0] in_amt_imm5,
  input  logic [DATA_W-1:0]  in_amt_reg,
  input  logic               in_carry,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [DATA_W-1:0]  out_operand,
  output logic               out_carry
);
  localparam int unsigned IMM_PAD = DATA_W - IMM_W;

  logic [AMT_W-1:0]  amount;
  logic              amount_zero;
  logic [DATA_W-1:0] shifted;
  logic              shift_carry;
  logic [DATA_W-1:0] operand_next;
  logic              carry_next;

  shop_amount_sel #(.DATA_W(DATA_W), .FIELD_W(FIELD_W), .AMT_W(AMT_W)) i_amt (
    .from_reg    (in_amt_from_reg),
    .field_amt   (in_amt_imm5),
    .reg_amt     (in_amt_reg),
    .amount      (amount),
    .amount_zero (amount_zero)
  );

  shop_barrel #(.DATA_W(DATA_W), .AMT_W(AMT_W)) i_barrel (
    .src         (in_src),
    .kind        (in_kind),
    .amount      (amount),
    .amount_zero (amount_zero),
    .carry_in    (in_carry),
    .result      (shifted),
    .carry_out   (shift_carry)
  );

  always_comb begin
    if (in_use_imm) begin
      operand_next = {{IMM_PAD{1'b0}}, in_imm8};
      carry_next   = in_carry;
    end else begin
      operand_next = shifted;
      carry_next   = shift_carry;
    end
  end

  shop_out_stage #(.DATA_W(DATA_W)) i_out (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_ready    (in_ready),
    .in_operand  (operand_next),
    .in_carry    (carry_next),
    .out_valid   (out_valid),
    .out_ready   (out_ready),
    .out_operand (out_operand),
    .out_carry   (out_carry)
  );

  logic taken;
  assign taken = in_valid && in_ready;

  a_r1_const_operand: assert property (@(posedge clk) disable iff (!rst_n)
    (taken && in_use_imm) |=>
      (out_operand == {{IMM_PAD{1'b0}}, $past(in_imm8)} && out_carry == $past(in_carry)));

  a_r3_zero_amount_passes: assert property (@(posedge clk) disable iff (!rst_n)
    (taken && !in_use_imm && kind_uses_amount(in_kind) && amount == '0) |=>
      (out_operand == $past(in_src) && out_carry == $past(in_carry)));

  a_r8_rotate_through_carry: assert property (@(posedge clk) disable iff (!rst_n)
    (taken && !in_use_imm && in_kind == SK_RCX) |=>
      (out_carry == $past(in_src[0]) && out_operand[DATA_W-1] == $past(in_carry)));

  a_r9_far_logical_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (taken && !in_use_imm && (in_kind == SK_SHL || in_kind == SK_SHR) &&
     amount > AMT_W'(DATA_W)) |=>
      (out_operand == '0 && !out_carry));

  a_r10_spare_codes_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (taken && !in_use_imm && in_kind > SK_RCX) |=>
      (out_operand == $past(in_src) && out_carry == $past(in_carry)));
endmodule

// File: tb/test_shop_operand_unit.sv
`timescale 1ns/1ps
module test_shop_operand_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic        in_use_imm = 1'b0;
  logic [7:0]  in_imm8 = '0;
  logic [31:0] in_src = '0;
  logic [2:0]  in_kind = '0;
  logic        in_amt_from_reg = 1'b0;
  logic [4:0]  in_amt_imm5 = '0;
  logic [31:0] in_amt_reg = '0;
  logic        in_carry = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_operand;
  logic        out_carry;

  always #2 clk = ~clk;

  shop_operand_unit i_shop_operand_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_use_imm(in_use_imm), .in_imm8(in_imm8), .in_src(in_src), .in_kind(in_kind),
    .in_amt_from_reg(in_amt_from_reg), .in_amt_imm5(in_amt_imm5), .in_amt_reg(in_amt_reg),
    .in_carry(in_carry), .out_valid(out_valid), .out_ready(out_ready),
    .out_operand(out_operand), .out_carry(out_carry)
  );

  int    checks = 0;
  int    fails = 0;
  bit    random_ready = 1'b0;
  string drv_tag = "R1";

  // Behavioural reference: one bit per step, returns {carry, operand}.
  function automatic logic [32:0] ref_op(input logic use_imm, input logic [7:0] imm,
      input logic [31:0] v, input logic [2:0] kind, input int n, input logic cin);
    logic [31:0] r = v;
    logic        c = cin;
    if (use_imm) return {cin, 24'd0, imm};
    case (kind)
      3'd0: for (int i = 0; i < n; i++) begin c = r[31]; r = r << 1; end
      3'd1: for (int i = 0; i < n; i++) begin c = r[0]; r = r >> 1; end
      3'd2: for (int i = 0; i < n; i++) begin c = r[0]; r = {r[31], r[31:1]}; end
      3'd3: for (int i = 0; i < n; i++) begin c = r[0]; r = {r[0], r[31:1]}; end
      3'd4: begin c = v[0]; r = {cin, v[31:1]}; end
      default: ;
    endcase
    return {c, r};
  endfunction

  logic        exp_valid = 1'b0;
  logic [31:0] exp_op = '0;
  logic        exp_c = 1'b0;
  string       exp_tag = "R12";

  always @(posedge clk) begin
    logic [32:0] e;
    int n;
    if (!rst_n) exp_valid <= 1'b0;
    else if (!exp_valid || out_ready) begin
      exp_valid <= in_valid;
      if (in_valid) begin
        n = in_amt_from_reg ? int'(in_amt_reg[7:0]) : int'(in_amt_imm5);
        e = ref_op(in_use_imm, in_imm8, in_src, in_kind, n, in_carry);
        exp_op  <= e[31:0];
        exp_c   <= e[32];
        exp_tag <= drv_tag;
      end
    end
  end

  task automatic check(input string tag, input string what, input logic [31:0] act,
                       input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, expv);
    end
  endtask

  always @(negedge clk) begin
    string vtag;
    vtag = rst_n ? "R11" : "R12";
    check(vtag, "out_valid", {31'd0, out_valid}, {31'd0, exp_valid});
    check(vtag, "in_ready", {31'd0, in_ready}, {31'd0, (!exp_valid || out_ready)});
    if (rst_n && exp_valid) begin
      check(exp_tag, "operand", out_operand, exp_op);
      check(exp_tag, "carry", {31'd0, out_carry}, {31'd0, exp_c});
    end
  end

  always @(posedge clk) begin
    #1;
    if (random_ready) out_ready = ($urandom % 3) != 0;
    else out_ready = 1'b1;
  end

  task automatic send(input string tag, input logic use_imm, input logic [7:0] imm,
      input logic [31:0] src, input logic [2:0] kind, input logic from_reg,
      input logic [4:0] f5, input logic [31:0] areg, input logic cin);
    logic took;
    @(posedge clk); #1;
    drv_tag = tag; in_valid = 1'b1; in_use_imm = use_imm; in_imm8 = imm; in_src = src;
    in_kind = kind; in_amt_from_reg = from_reg; in_amt_imm5 = f5; in_amt_reg = areg;
    in_carry = cin;
    took = 1'b0;
    while (!took) begin
      #1;
      took = in_ready;
      @(posedge clk);
    end
    #1;
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 constant operand, kind and amount ignored
    send("R1", 1, 8'hFF, 32'hDEAD0000, 3'd0, 1, 5'd3, 32'h5, 1);
    send("R1", 1, 8'h00, 32'h12345678, 3'd4, 0, 5'd9, 32'h0, 0);
    // R2 amount source
    send("R2", 0, 0, 32'h3, 3'd0, 1, 5'd7, 32'hABCDEF01, 0);
    send("R2", 0, 0, 32'h1, 3'd0, 0, 5'd4, 32'hFFFFFFFF, 0);
    // R3 zero amount
    send("R3", 0, 0, 32'h12345678, 3'd3, 1, 5'd9, 32'h00000100, 1);
    send("R3", 0, 0, 32'hFFFFFFFF, 3'd1, 0, 5'd0, 32'h0, 0);
    send("R3", 0, 0, 32'h80000001, 3'd0, 0, 5'd0, 32'h0, 1);
    // R4 left logical
    send("R4", 0, 0, 32'h80000004, 3'd0, 0, 5'd1, 32'h0, 0);
    send("R4", 0, 0, 32'h5, 3'd0, 0, 5'd3, 32'h0, 0);
    send("R4", 0, 0, 32'h1, 3'd0, 1, 5'd0, 32'd32, 0);
    // R5 right logical
    send("R5", 0, 0, 32'h1F, 3'd1, 0, 5'd4, 32'h0, 0);
    send("R5", 0, 0, 32'h80000000, 3'd1, 1, 5'd0, 32'd32, 0);
    // R6 right arithmetic
    send("R6", 0, 0, 32'h80000010, 3'd2, 0, 5'd4, 32'h0, 0);
    send("R6", 0, 0, 32'h80000000, 3'd2, 1, 5'd0, 32'd200, 0);
    send("R6", 0, 0, 32'h7FFFFFFF, 3'd2, 1, 5'd0, 32'd32, 1);
    // R7 rotate right
    send("R7", 0, 0, 32'hAB, 3'd3, 0, 5'd8, 32'h0, 0);
    send("R7", 0, 0, 32'h80000001, 3'd3, 1, 5'd0, 32'd64, 0);
    send("R7", 0, 0, 32'h00000002, 3'd3, 1, 5'd0, 32'd33, 0);
    // R8 rotate through carry
    send("R8", 0, 0, 32'h3, 3'd4, 0, 5'd7, 32'h0, 1);
    send("R8", 0, 0, 32'hFFFFFFFE, 3'd4, 1, 5'd0, 32'd40, 0);
    // R9 far logical
    send("R9", 0, 0, 32'hFFFFFFFF, 3'd0, 1, 5'd0, 32'd33, 1);
    send("R9", 0, 0, 32'hFFFFFFFF, 3'd1, 1, 5'd0, 32'd255, 1);
    // R10 spare codes
    send("R10", 0, 0, 32'hCAFEF00D, 3'd6, 0, 5'd5, 32'h0, 1);
    send("R10", 0, 0, 32'h0F0F0F0F, 3'd7, 1, 5'd0, 32'd3, 0);
    // R11 random traffic with back-pressure
    random_ready = 1'b1;
    for (int k = 0; k < 1500; k++) begin
      logic [2:0] kd;
      string t;
      kd = 3'($urandom % 8);
      case (kd)
        3'd0: t = "R4"; 3'd1: t = "R5"; 3'd2: t = "R6"; 3'd3: t = "R7";
        3'd4: t = "R8"; default: t = "R10";
      endcase
      if (($urandom % 8) == 0) t = "R1";
      send(t, t == "R1", 8'($urandom), $urandom, kd, 1'($urandom),
           5'($urandom), (($urandom % 2) == 0) ? ($urandom % 70) : $urandom, 1'($urandom));
    end
    random_ready = 1'b0;
    repeat (4) @(posedge clk);
    // R12 reset mid-stream
    #1 rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) @(posedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule